// File: doc/BRIEF.md
# Packed Floating-Point Mantissa/Exponent Multiplier

This block multiplies two operands held in a compact floating-point word. Each operand word is 16 bits: a 12-bit two's-complement mantissa with its binary point just below the sign bit, and a 4-bit two's-complement exponent. The mantissa product is formed with radix-4 Booth recoding. To save adders, partial-product bits in the lowest columns are never summed, so the result is truncated. Only the upper 16 bits of the product are kept as the result mantissa. The two exponents are added, and the result is then corrected for exponent overflow, exponent underflow and the single mantissa overflow case.

A mode input turns the block into a plain fixed-point 12x12 multiplier. In that mode the exponent fields are ignored and the result exponent is zero.

The caller presents both packed operands, the mode bit and a one-cycle strobe. The 20-bit result word carries the mantissa above the exponent. It is registered, appears one clock after the strobe, and is held until the next strobe.

Top module: `fmx_multiplier`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle with `in_valid` high. Synchronous reset clears `res_valid` and `res_word` to zero.
- R2: `res_word` changes only after a strobe. While `in_valid` is low it keeps its last value.
- R3: Operand layout and product rule:
  - Operand bits 15..4 are the mantissa and bits 3..0 are the exponent. Result bits 19..4 are the mantissa and bits 3..0 are the exponent.
  - Take the six radix-4 Booth digits of Y: d_i = -2*y[2i+1] + y[2i] + y[2i-1], with y[-1] = 0.
  - Each row is |d_i|*X sign-extended to 24 bits, bitwise inverted when d_i < 0, and shifted left by 2i. A negative row also gets a +1 at column 2i.
  - Every bit of a row or a +1 that falls in columns 0..5 is discarded. The remaining rows are summed modulo 2^24.
  - The result mantissa is bits 22..7 of that sum.
- R4: A zero X mantissa does not force a zero result. For example, X mantissa 0x000 and Y mantissa 0x002 in fixed mode give mantissa 0xFFFF.
- R5: A zero Y mantissa gives a zero product mantissa.
- R6: When both mantissas are 0x800 (-1), the result mantissa is replaced by 0x7FFF. This applies in both modes.
- R7: In floating mode, when the exponent sum s lies in -7..+7, the result exponent is s and the mantissa is the product unchanged.
- R8: In floating mode, when s = +8 and the product mantissa is not normalized (bit 15 equals bit 14), the mantissa is shifted left by one and the exponent is +7.
- R9: In floating mode, the mantissa saturates and the exponent becomes +7 when either:
  - s > +8, or
  - s = +8 and the mantissa is normalized.

  The saturated mantissa keeps the sign: 0x7FFF if bit 15 is 0, 0x8000 if bit 15 is 1.
- R10: In floating mode, when s <= -8, the exponent is -8 (code 0x8) and the mantissa is arithmetically shifted right by (-8 - s).
- R11: In fixed mode, the exponent fields are ignored, the result exponent is 0, and only R6 alters the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe, one cycle per multiply |
| fixed_mode | input | 1 | 1 selects fixed-point, 0 selects floating-point |
| op_x | input | 16 | Packed X operand (mantissa 15..4, exponent 3..0) |
| op_y | input | 16 | Packed Y operand (mantissa 15..4, exponent 3..0) |
| res_valid | output | 1 | High one cycle after a strobe |
| res_word | output | 20 | Registered result (mantissa 19..4, exponent 3..0) |

## Verification
The product rule is exercised with several kinds of operands, each separating a different fault:
- Mantissa pairs with exact powers of two, which show whether the output slice is in the right place.
- Y values with negative Booth digits only in the low groups, which show whether the low-column drops and the dropped +1 corrections are right.
- The -1 times -1 pair, which catches a missing overflow fix.
- Random mantissas, which catch recoding errors.

The protection logic is covered separately. A full sweep of all 256 exponent pairs over a normalized mantissa and an unnormalized one separates the in-range, left-shift, saturate and right-shift branches and their boundaries at +8 and -8. Fixed-mode vectors with random exponent fields show that those fields have no effect. Strobe gaps show that the result is held.

// File: rtl/fmx_pkg.sv
package fmx_pkg;
  localparam int FMX_MAN_W  = 12;
  localparam int FMX_EXP_W  = 4;
  localparam int FMX_OUT_W  = 16;
  localparam int FMX_DROP_W = 6;

  typedef enum logic {
    MODE_FLOAT = 1'b0,
    MODE_FIXED = 1'b1
  } fmx_mode_e;
endpackage

// File: rtl/fmx_booth_row.sv
module fmx_booth_row #(
  parameter int MAN_W = 12,
  parameter int PW    = 24,
  parameter int IDX   = 0,
  parameter int DROP  = 6
) (
  input  logic [MAN_W-1:0] x_man,
  input  logic [2:0]       y_tri,
  output logic [PW-1:0]    row,
  output logic [PW-1:0]    corr
);
  localparam int SH = 2 * IDX;
  localparam logic [PW-1:0] KEEP = ~((PW'(1) << DROP) - PW'(1));

  logic [PW-1:0] xs, mag, inv;
  logic one, two, neg;

  assign one = y_tri[1] ^ y_tri[0];
  assign two = (y_tri[2] & ~y_tri[1] & ~y_tri[0]) | (~y_tri[2] & y_tri[1] & y_tri[0]);
  assign neg = y_tri[2] & ~(y_tri[1] & y_tri[0]);

  assign xs  = PW'($signed(x_man));
  assign mag = two ? (xs << 1) : (one ? xs : '0);
  assign inv = neg ? ~mag : mag;
  assign row = (inv << SH) & KEEP;

  generate
    if (SH >= DROP) begin : g_corr
      assign corr = neg ? (PW'(1) << SH) : '0;
    end else begin : g_nocorr
      assign corr = '0;
    end
  endgenerate
endmodule

// File: rtl/fmx_booth_array.sv
module fmx_booth_array #(
  parameter int MAN_W = 12,
  parameter int DROP  = 6,
  localparam int PW   = 2 * MAN_W,
  localparam int NPP  = MAN_W / 2
) (
  input  logic [MAN_W-1:0]          x_man,
  input  logic [MAN_W-1:0]          y_man,
  output logic [NPP-1:0][PW-1:0]    rows,
  output logic [NPP-1:0][PW-1:0]    corrs
);
  logic [MAN_W:0] y_ext;
  assign y_ext = {y_man, 1'b0};

  genvar g;
  generate
    for (g = 0; g < NPP; g++) begin : g_row
      fmx_booth_row #(
        .MAN_W(MAN_W), .PW(PW), .IDX(g), .DROP(DROP)
      ) u_row (
        .x_man(x_man),
        .y_tri(y_ext[2*g+2:2*g]),
        .row  (rows[g]),
        .corr (corrs[g])
      );
    end
  endgenerate
endmodule

// File: rtl/fmx_adder.sv
module fmx_adder #(
  parameter int MAN_W = 12,
  parameter int OUT_W = 16,
  localparam int PW   = 2 * MAN_W,
  localparam int NPP  = MAN_W / 2,
  localparam int LO   = PW - 1 - OUT_W
) (
  input  logic [NPP-1:0][PW-1:0] rows,
  input  logic [NPP-1:0][PW-1:0] corrs,
  output logic [OUT_W-1:0]       man_hi
);
  logic [PW-1:0] acc;
  logic          unused_bits;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NPP; i++) begin
      acc = acc + rows[i] + corrs[i];
    end
  end

  assign man_hi      = acc[PW-2:LO];
  assign unused_bits = ^{acc[PW-1], acc[LO-1:0]};
endmodule

// File: rtl/fmx_protect.sv
module fmx_protect #(
  parameter int OUT_W = 16,
  parameter int EXP_W = 4
) (
  input  logic             fixed_mode,
  input  logic             neg_one_pair,
  input  logic [OUT_W-1:0] raw_man,
  input  logic [EXP_W-1:0] ex,
  input  logic [EXP_W-1:0] ey,
  output logic [OUT_W-1:0] man_o,
  output logic [EXP_W-1:0] exp_o
);
  import fmx_pkg::*;
  localparam int EMAX = 2 ** (EXP_W - 1) - 1;
  localparam int EMIN = -(2 ** (EXP_W - 1));
  localparam logic [OUT_W-1:0] MAXPOS = {1'b0, {(OUT_W-1){1'b1}}};

  logic [OUT_W-1:0] base_man;
  logic             normed;
  int               s_i;
  int               sh;

  assign base_man = neg_one_pair ? MAXPOS : raw_man;
  assign normed   = base_man[OUT_W-1] ^ base_man[OUT_W-2];

  always_comb begin
    s_i   = int'($signed(ex)) + int'($signed(ey));
    sh    = EMIN - s_i;
    man_o = base_man;
    exp_o = EXP_W'(s_i);
    if (fixed_mode == MODE_FIXED) begin
      exp_o = '0;
    end else if (s_i > EMAX + 1 || (s_i == EMAX + 1 && normed)) begin
      man_o = {base_man[OUT_W-1], {(OUT_W-1){~base_man[OUT_W-1]}}};
      exp_o = EXP_W'(EMAX);
    end else if (s_i == EMAX + 1) begin
      man_o = base_man << 1;
      exp_o = EXP_W'(EMAX);
    end else if (s_i <= EMIN) begin
      man_o = OUT_W'($signed(base_man) >>> sh);
      exp_o = EXP_W'(EMIN);
    end
  end
endmodule

// File: rtl/fmx_multiplier.sv
module fmx_multiplier #(
  parameter int MAN_W  = fmx_pkg::FMX_MAN_W,
  parameter int EXP_W  = fmx_pkg::FMX_EXP_W,
  parameter int OUT_W  = fmx_pkg::FMX_OUT_W,
  parameter int DROP   = fmx_pkg::FMX_DROP_W,
  localparam int OP_W  = MAN_W + EXP_W,
  localparam int RES_W = OUT_W + EXP_W,
  localparam int PW    = 2 * MAN_W,
  localparam int NPP   = MAN_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             fixed_mode,
  input  logic [OP_W-1:0]  op_x,
  input  logic [OP_W-1:0]  op_y,
  output logic             res_valid,
  output logic [RES_W-1:0] res_word
);
  localparam logic [MAN_W-1:0] MINUS_ONE = {1'b1, {(MAN_W-1){1'b0}}};

  logic [MAN_W-1:0]          x_man, y_man;
  logic [EXP_W-1:0]          x_exp, y_exp;
  logic [NPP-1:0][PW-1:0]    rows, corrs;
  logic [OUT_W-1:0]          raw_man, fin_man;
  logic [EXP_W-1:0]          fin_exp;
  logic                      neg_one_pair;

  assign x_man = op_x[OP_W-1:EXP_W];
  assign y_man = op_y[OP_W-1:EXP_W];
  assign x_exp = op_x[EXP_W-1:0];
  assign y_exp = op_y[EXP_W-1:0];
  assign neg_one_pair = (x_man == MINUS_ONE) && (y_man == MINUS_ONE);

  fmx_booth_array #(.MAN_W(MAN_W), .DROP(DROP)) u_array (
    .x_man(x_man), .y_man(y_man), .rows(rows), .corrs(corrs)
  );

  fmx_adder #(.MAN_W(MAN_W), .OUT_W(OUT_W)) u_adder (
    .rows(rows), .corrs(corrs), .man_hi(raw_man)
  );

  fmx_protect #(.OUT_W(OUT_W), .EXP_W(EXP_W)) u_protect (
    .fixed_mode(fixed_mode), .neg_one_pair(neg_one_pair), .raw_man(raw_man),
    .ex(x_exp), .ey(y_exp), .man_o(fin_man), .exp_o(fin_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_word  <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_word <= {fin_man, fin_exp};
    end
  end
endmodule

// File: rtl/fmx_multiplier_chk.sv
module fmx_multiplier_chk #(
  parameter int MAN_W = 12,
  parameter int EXP_W = 4,
  parameter int OUT_W = 16,
  localparam int OP_W  = MAN_W + EXP_W,
  localparam int RES_W = OUT_W + EXP_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             fixed_mode,
  input logic [OP_W-1:0]  op_x,
  input logic [OP_W-1:0]  op_y,
  input logic             res_valid,
  input logic [RES_W-1:0] res_word
);
  localparam int EMAX = 2 ** (EXP_W - 1) - 1;
  localparam int EMIN = -(2 ** (EXP_W - 1));
  localparam logic [MAN_W-1:0] MONE = {1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] MAXP = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MAXN = {1'b1, {(OUT_W-1){1'b0}}};

  int s_chk;
  assign s_chk = int'($signed(op_x[EXP_W-1:0])) + int'($signed(op_y[EXP_W-1:0]));

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_word));
  assert_zero_y_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fixed_mode && op_y[OP_W-1:EXP_W] == '0) |=> res_word[RES_W-1:EXP_W] == '0);
  assert_neg_one_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fixed_mode && op_x[OP_W-1:EXP_W] == MONE && op_y[OP_W-1:EXP_W] == MONE)
      |=> res_word[RES_W-1:EXP_W] == MAXP);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !fixed_mode && s_chk > EMAX + 1)
      |=> (res_word[EXP_W-1:0] == EXP_W'(EMAX)) &&
          (res_word[RES_W-1:EXP_W] == MAXP || res_word[RES_W-1:EXP_W] == MAXN));
  assert_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !fixed_mode && s_chk <= EMIN) |=> res_word[EXP_W-1:0] == EXP_W'(EMIN));
  assert_fixed_exp_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fixed_mode) |=> res_word[EXP_W-1:0] == '0);
endmodule

bind fmx_multiplier fmx_multiplier_chk #(
  .MAN_W(MAN_W), .EXP_W(EXP_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .fixed_mode(fixed_mode),
  .op_x(op_x), .op_y(op_y), .res_valid(res_valid), .res_word(res_word)
);

// File: tb/test_fmx_multiplier.sv
module test_fmx_multiplier;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        fixed_mode = 1'b0;
  logic [15:0] op_x = '0;
  logic [15:0] op_y = '0;
  logic        res_valid;
  logic [19:0] res_word;

  int checks = 0;
  int fails  = 0;
  logic        exp_v = 1'b0;
  logic [19:0] exp_w = '0;
  string       exp_tag = "R1";

  always #4 clk = ~clk;

  fmx_multiplier i_fmx_multiplier (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fixed_mode(fixed_mode),
    .op_x(op_x), .op_y(op_y), .res_valid(res_valid), .res_word(res_word)
  );

  function automatic int ybit(input logic [11:0] y, input int k);
    return (k < 0) ? 0 : int'(y[k]);
  endfunction

  function automatic logic [19:0] model(input logic [15:0] ox, input logic [15:0] oy,
                                        input logic fx);
    longint msk = 64'hFF_FFFF;
    longint sum = 0;
    longint xs  = longint'($signed(ox[15:4]));
    logic [15:0] man;
    int s;
    for (int i = 0; i < 6; i++) begin
      int d = -2 * ybit(oy[15:4], 2*i+1) + ybit(oy[15:4], 2*i) + ybit(oy[15:4], 2*i-1);
      longint v = ((d < 0) ? -d : d) * xs;
      longint c = 0;
      v = v & msk;
      if (d < 0) begin
        v = ~v & msk;
        c = longint'(1) << (2*i);
      end
      v = (v << (2*i)) & msk & ~longint'(63);
      if (2*i < 6) c = 0;
      sum = (sum + v + c) & msk;
    end
    man = 16'((sum >> 7) & 64'hFFFF);
    if (ox[15:4] == 12'h800 && oy[15:4] == 12'h800) man = 16'h7FFF;
    if (fx) return {man, 4'h0};
    s = int'($signed(ox[3:0])) + int'($signed(oy[3:0]));
    if (s > 8 || (s == 8 && man[15] != man[14]))
      return {man[15] ? 16'h8000 : 16'h7FFF, 4'h7};
    if (s == 8) return {man << 1, 4'h7};
    if (s <= -8) return {16'($signed(man) >>> (-8 - s)), 4'h8};
    return {man, 4'(s)};
  endfunction

  function automatic string tag_for(input logic [15:0] ox, input logic [15:0] oy,
                                    input logic fx);
    int s = int'($signed(ox[3:0])) + int'($signed(oy[3:0]));
    if (fx) return "R11";
    if (s == 8) return "R8/R9";
    if (s > 8) return "R9";
    if (s <= -8) return "R10";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic [19:0] got, input logic [19:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  // One clock: check what the previous cycle produced, then drive the next inputs.
  task automatic step(input logic v, input logic [15:0] ox, input logic [15:0] oy,
                      input logic fx, input string tag, input logic use_hand,
                      input logic [19:0] hand);
    @(negedge clk);
    check({exp_tag, " valid"}, {19'b0, res_valid}, {19'b0, exp_v});
    check(exp_v ? exp_tag : "R2", res_word, exp_w);
    in_valid = v; op_x = ox; op_y = oy; fixed_mode = fx;
    exp_v = v;
    if (v) begin
      exp_w   = use_hand ? hand : model(ox, oy, fx);
      exp_tag = tag;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {19'b0, res_valid}, 20'h0);
    check("R1 reset word", res_word, 20'h0);
    @(negedge clk);
    rst = 1'b0;
    // hand-computed corner values
    step(1, 16'h4000, 16'h4000, 0, "R3 half*half", 1, 20'h20000);
    step(1, 16'h0000, 16'h0020, 1, "R4 zero X", 1, 20'hFFFF0);
    step(1, 16'h5551, 16'h0002, 0, "R5 zero Y", 1, 20'h00003);
    step(1, 16'h8003, 16'h8005, 1, "R6 minus one pair", 1, 20'h7FFF0);
    step(0, 16'h1234, 16'h5678, 0, "R2", 0, 20'h0);
    step(0, 16'h7FF7, 16'h7FF7, 0, "R2", 0, 20'h0);
    step(1, 16'h4001, 16'h4002, 0, "R7 in range", 1, 20'h20003);
    step(1, 16'h4004, 16'h4004, 0, "R8 shift left", 1, 20'h40007);
    step(1, 16'h6004, 16'h6004, 0, "R9 sat at +8", 1, 20'h7FFF7);
    step(1, 16'h4007, 16'h4003, 0, "R9 sat above +8", 1, 20'h7FFF7);
    step(1, 16'h4008, 16'h400E, 0, "R10 underflow", 1, 20'h08008);
    step(1, 16'h4007, 16'h4007, 1, "R11 fixed ignores exp", 1, 20'h20000);
    // exponent sweep over two mantissa pairs
    for (int e = 0; e < 256; e++) begin
      logic [15:0] a = {12'h600, 4'(e >> 4)};
      logic [15:0] b = {12'h600, 4'(e)};
      step(1, a, b, 0, tag_for(a, b, 0), 0, 20'h0);
      a = {12'h9A3, 4'(e >> 4)};
      b = {12'h0C5, 4'(e)};
      step(1, a, b, 0, tag_for(a, b, 0), 0, 20'h0);
    end
    // random operands, random mode and strobe gaps
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a = 16'($urandom);
      logic [15:0] b = 16'($urandom);
      logic f = 1'($urandom);
      logic v = ($urandom % 4) != 0;
      step(v, a, b, f, (n % 2) ? "R3" : tag_for(a, b, f), 0, 20'h0);
    end
    step(0, 16'h0, 16'h0, 0, "R2", 0, 20'h0);
    step(0, 16'h0, 16'h0, 0, "R2", 0, 20'h0);
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule